// File: doc/BRIEF.md
# Ring Buffer Sequencer Status Flags

This block holds the pointer and flag state that sequences an anti-skip audio ring buffer kept in external memory. It tracks three addresses: a write pointer that moves with each word stored, a read pointer that moves with each word handed out, and a valid-end pointer that marks the first address past data whose block sync has been verified. From these pointers and from host commands it derives six flags: write-sequence running, read-sequence running, buffer empty, write overflow, sync warning and read stopped. The flags are packed into two status bytes for the host.

The host drives a control strobe that carries write-enable, read-enable, two compare-connect start bits and a master-on bit. It also drives strobes that clear the read address or the write address, and a strobe that reads status byte 0. The input stream side supplies a block-verified pulse, a block-failed pulse and one pulse per received byte. A compare-connect match and a direct-connect completion each arrive as single-cycle pulses. An external buffer-overflow pulse is also accepted. For every flag, a clear condition arriving in the same cycle as a set condition wins.

Top module: `rbuf_seq_flags`

## Requirements
- R1: After the active-low synchronous reset, all three pointers are 0. Write-sequence, read-sequence, overflow, sync warning and read-stopped are 0. Empty is 1, so status byte 0 reads 0x00 and status byte 1 reads 0x80.
- R2: Status byte 0 carries sync warning at bit 0 and read-stopped at bit 1. Status byte 1 carries empty at bit 7, overflow at bit 6, write-sequence at bit 5 and read-sequence at bit 4. Every other bit reads 0.
- R3: The write pointer advances by one on each cycle with `wr_word` high while write-sequence is 1. The read pointer advances by one on each cycle with `rd_word` high while read-sequence is 1 and empty is 0. Both wrap from BUF_WORDS-1 to 0. A `sync_ok` pulse copies the write pointer into the valid-end pointer.
- R4: Empty equals 1 exactly when the valid-end pointer equals the read pointer, with no added cycle of lag.
- R5: Overflow becomes 1 when a write moves the write pointer onto the read pointer. Equality of the two pointers caused by an address clear or by reset never sets it.
- R6: Overflow is cleared by a read-pointer advance, by either address-clear strobe and by reset. These clears win over a simultaneous set.
- R7: Sync warning is set by a `sync_fail` pulse, or by SYNC_WIN byte pulses with no `sync_ok` in between. It is cleared by `stat0_rd`, by either address-clear strobe and by reset. The clear wins over a simultaneous set.
- R8: Read-stopped is set when read-sequence is 1 while empty is 1. It is cleared by `stat0_rd` and by either address-clear strobe, and the clear wins.
- R9: Write-sequence is set by a control strobe with write-enable 1, by a `cc_match` pulse, or by a `dconn_done` pulse.
- R10: Write-sequence is cleared by any of the following: sync warning or its set event, overflow or its set event, a `buf_ovf` pulse, or a control strobe with write-enable 0, with a nonzero compare-connect start field, or with master-on 0. Each of these wins over every set source. Write-enable 1 sent together with a compare-connect start therefore leaves write-sequence at 0.
- R11: Read-sequence is set only by a control strobe with read-enable 1 while empty is 0. It is cleared when empty is 1 or when a control strobe carries read-enable 0. A read-enable command while empty has no effect.
- R12: `clr_rd_addr` sets the read pointer to 0. `clr_wr_addr` sets the write and valid-end pointers to 0. Each clear wins over a same-cycle advance or copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Control command strobe |
| ctl_wr_en | input | 1 | Write-enable bit of the command |
| ctl_rd_en | input | 1 | Read-enable bit of the command |
| ctl_cc_start | input | 2 | Compare-connect start bits of the command |
| ctl_master_on | input | 1 | Master-on bit of the command |
| clr_rd_addr | input | 1 | Read address clear strobe |
| clr_wr_addr | input | 1 | Write address clear strobe |
| stat0_rd | input | 1 | Status byte 0 read strobe (clears its flags) |
| cc_match | input | 1 | Compare-connect match pulse |
| dconn_done | input | 1 | Direct connect completion pulse |
| buf_ovf | input | 1 | External buffer-overflow pulse |
| sync_ok | input | 1 | Block sync verified pulse |
| sync_fail | input | 1 | Block sync not verified pulse |
| byte_tick | input | 1 | One input byte received |
| wr_word | input | 1 | Word offered for storage |
| rd_word | input | 1 | Word requested for output |
| stat0 | output | 8 | Status byte 0 |
| stat1 | output | 8 | Status byte 1 |
| wr_addr | output | AW | Write pointer |
| rd_addr | output | AW | Read pointer |
| vend_addr | output | AW | Valid-end pointer |

## Verification
The assertions check several relations on every cycle. Empty must match the pointer comparison. Overflow must force the write sequence off on the next cycle, and an address clear must leave overflow and sync warning at 0. A rise of read-sequence or read-stopped must trace back to its allowed cause. The byte counter must stay inside its window. The bench scenarios cover what single-cycle properties cannot show. These include a full lap of the write pointer that ends in overflow, the exact byte count at which the sync timeout fires, and the drain of the read pointer to empty followed by the stop. They also include each write-sequence start and stop source taken one at a time, and the clear-over-set outcomes when two strobes coincide.

// File: rtl/rbuf_pkg.sv
// Package: shared constants and helpers for the ring buffer flag logic.
// Assumes: status bytes are 8 bits; bit positions below are the host contract.
package rbuf_pkg;

    localparam int STAT_W     = 8;
    localparam int S0_SYNCWAR = 0;
    localparam int S0_RDSTOP  = 1;
    localparam int S1_RDSQ    = 4;
    localparam int S1_WRSQ    = 5;
    localparam int S1_OVFL    = 6;
    localparam int S1_EMPTY   = 7;

    typedef struct packed {
        logic empty;
        logic ovfl;
        logic wrsq;
        logic rdsq;
        logic syncwar;
        logic rdstop;
    } flags_t;

    // Build status byte 0 from the flag set.
    function automatic logic [STAT_W-1:0] pack_stat0(flags_t f);
        logic [STAT_W-1:0] s;
        s = '0;
        s[S0_SYNCWAR] = f.syncwar;
        s[S0_RDSTOP]  = f.rdstop;
        return s;
    endfunction

    // Build status byte 1 from the flag set.
    function automatic logic [STAT_W-1:0] pack_stat1(flags_t f);
        logic [STAT_W-1:0] s;
        s = '0;
        s[S1_EMPTY] = f.empty;
        s[S1_OVFL]  = f.ovfl;
        s[S1_WRSQ]  = f.wrsq;
        s[S1_RDSQ]  = f.rdsq;
        return s;
    endfunction

endpackage

// File: rtl/rbuf_addr_track.sv
// Module: rbuf_addr_track
// Holds the write, read and valid-end pointers of the ring and a registered
// empty flag computed from the next-state pointers, so empty never lags.
// Assumes: wr_go/rd_go are already qualified by the sequence flags;
// BUF_WORDS is at least 2 and at most 2**AW.
module rbuf_addr_track #(
    parameter int AW        = 20,
    parameter int BUF_WORDS = 1 << 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic          rd_go,
    input  logic          commit,
    input  logic          clr_rd,
    input  logic          clr_wr,
    output logic [AW-1:0] wa,
    output logic [AW-1:0] ra,
    output logic [AW-1:0] vwa,
    output logic          empty,
    output logic          wr_meets_rd
);

    localparam logic [AW-1:0] LAST = AW'(BUF_WORDS - 1);

    logic [AW-1:0] wa_n, ra_n, vwa_n, wa_inc, ra_inc;

    // Advance a pointer by one with wrap at the buffer end.
    function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Next-state pointers; a clear outranks movement.
    always_comb begin
        wa_inc = wrap_inc(wa);
        ra_inc = wrap_inc(ra);
        wa_n   = clr_wr ? '0 : (wr_go ? wa_inc : wa);
        vwa_n  = clr_wr ? '0 : (commit ? wa : vwa);
        ra_n   = clr_rd ? '0 : (rd_go ? ra_inc : ra);
    end

    // A real write lands the write pointer on the read pointer.
    assign wr_meets_rd = wr_go && !clr_wr && (wa_inc == ra);

    // Pointer and empty registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa    <= '0;
            ra    <= '0;
            vwa   <= '0;
            empty <= 1'b1;
        end else begin
            wa    <= wa_n;
            ra    <= ra_n;
            vwa   <= vwa_n;
            empty <= (vwa_n == ra_n);
        end
    end

    // R4
    empty_tracks_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (vwa == ra));

    // R3
    wr_ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !clr_wr) |=> (wa != $past(wa)));

    // R12
    rd_clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rd |=> (ra == '0));

endmodule

// File: rtl/rbuf_sync_watch.sv
// Module: rbuf_sync_watch
// Counts input bytes since the last verified sync and raises the sync
// warning flag on a failed block or on a window with no sync.
// Assumes: sync_ok restarts the window; clr outranks any set.
module rbuf_sync_watch #(
    parameter int SYNC_WIN = 2352
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_ok,
    input  logic sync_fail,
    input  logic byte_tick,
    input  logic clr,
    output logic syncwar,
    output logic sw_set
);

    localparam int CW = $clog2(SYNC_WIN);
    localparam logic [CW-1:0] LIM = CW'(SYNC_WIN - 1);

    logic [CW-1:0] cnt;
    logic          timeout;

    // Window expires on the byte that would pass the limit.
    assign timeout = byte_tick && !sync_ok && (cnt == LIM);
    assign sw_set  = (sync_fail || timeout) && !clr;

    // Byte counter within the sync window.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (sync_ok)      cnt <= '0;
        else if (byte_tick)    cnt <= (cnt == LIM) ? '0 : cnt + 1'b1;
    end

    // Sync warning flag, clear before set.
    always_ff @(posedge clk) begin
        if (!rst_n)       syncwar <= 1'b0;
        else if (clr)     syncwar <= 1'b0;
        else if (sw_set)  syncwar <= 1'b1;
    end

    // R7
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !syncwar);

    // R7
    sync_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);

endmodule

// File: rtl/rbuf_flag_core.sv
// Module: rbuf_flag_core
// Sequence flags: write-sequence, read-sequence, overflow and read-stopped.
// Every flag applies its clear conditions ahead of its set conditions.
// Assumes: ctl_* fields are valid only while ctl_wr is high.
module rbuf_flag_core (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] cc_start,
    input  logic       master_on,
    input  logic       clr_any,
    input  logic       stat0_rd,
    input  logic       cc_match,
    input  logic       dconn_done,
    input  logic       buf_ovf,
    input  logic       syncwar,
    input  logic       sw_set,
    input  logic       empty,
    input  logic       wr_meets_rd,
    input  logic       rd_go,
    output logic       wrsq,
    output logic       rdsq,
    output logic       ovfl,
    output logic       rdstop
);

    logic ovf_clr, ovf_set, cmd_wstop, wr_stop, wr_start;
    logic rd_stop, rd_start, rs_clr, rs_set;

    // Clear and set terms for each flag.
    always_comb begin
        ovf_clr   = rd_go || clr_any;
        ovf_set   = wr_meets_rd && !ovf_clr;
        cmd_wstop = ctl_wr && (!wr_en || (|cc_start) || !master_on);
        wr_stop   = cmd_wstop || syncwar || sw_set || ovfl || ovf_set || buf_ovf;
        wr_start  = (ctl_wr && wr_en) || cc_match || dconn_done;
        rd_stop   = empty || (ctl_wr && !rd_en);
        rd_start  = ctl_wr && rd_en;
        rs_clr    = stat0_rd || clr_any;
        rs_set    = rdsq && empty;
    end

    // Overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovfl <= 1'b0;
        else if (ovf_clr)  ovfl <= 1'b0;
        else if (ovf_set)  ovfl <= 1'b1;
    end

    // Write-sequence flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         wrsq <= 1'b0;
        else if (wr_stop)   wrsq <= 1'b0;
        else if (wr_start)  wrsq <= 1'b1;
    end

    // Read-sequence flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdsq <= 1'b0;
        else if (rd_stop)   rdsq <= 1'b0;
        else if (rd_start)  rdsq <= 1'b1;
    end

    // Read-stopped flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdstop <= 1'b0;
        else if (rs_clr)   rdstop <= 1'b0;
        else if (rs_set)   rdstop <= 1'b1;
    end

    // R10
    ovfl_stops_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl |=> !wrsq);

    // R5
    no_overflow_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> !ovfl);

    // R11
    rdsq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdsq) |-> $past(ctl_wr && rd_en && !empty));

    // R8
    rdstop_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdstop) |-> $past(rdsq && empty));

endmodule

// File: rtl/rbuf_seq_flags.sv
// Module: rbuf_seq_flags (top)
// Ring buffer sequencer status flags: qualifies word movement with the
// sequence flags, ties pointer, sync and flag logic together and packs
// the two host status bytes.
// Assumes: single clock domain, synchronous active-low reset.
module rbuf_seq_flags
    import rbuf_pkg::*;
#(
    parameter int AW        = 20,
    parameter int BUF_WORDS = 1 << 20,
    parameter int SYNC_WIN  = 2352
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_wr_en,
    input  logic              ctl_rd_en,
    input  logic [1:0]        ctl_cc_start,
    input  logic              ctl_master_on,
    input  logic              clr_rd_addr,
    input  logic              clr_wr_addr,
    input  logic              stat0_rd,
    input  logic              cc_match,
    input  logic              dconn_done,
    input  logic              buf_ovf,
    input  logic              sync_ok,
    input  logic              sync_fail,
    input  logic              byte_tick,
    input  logic              wr_word,
    input  logic              rd_word,
    output logic [STAT_W-1:0] stat0,
    output logic [STAT_W-1:0] stat1,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     rd_addr,
    output logic [AW-1:0]     vend_addr
);

    logic   wrsq, rdsq, ovfl, rdstop, syncwar, sw_set, empty;
    logic   wr_go, rd_go, wr_meets_rd, clr_any, sw_clr;
    flags_t flags;

    // Word movement only while the matching sequence runs.
    assign wr_go   = wr_word && wrsq;
    assign rd_go   = rd_word && rdsq && !empty;
    assign clr_any = clr_rd_addr || clr_wr_addr;
    assign sw_clr  = stat0_rd || clr_any;

    rbuf_addr_track #(.AW(AW), .BUF_WORDS(BUF_WORDS)) addr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_go       (wr_go),
        .rd_go       (rd_go),
        .commit      (sync_ok),
        .clr_rd      (clr_rd_addr),
        .clr_wr      (clr_wr_addr),
        .wa          (wr_addr),
        .ra          (rd_addr),
        .vwa         (vend_addr),
        .empty       (empty),
        .wr_meets_rd (wr_meets_rd)
    );

    rbuf_sync_watch #(.SYNC_WIN(SYNC_WIN)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_ok   (sync_ok),
        .sync_fail (sync_fail),
        .byte_tick (byte_tick),
        .clr       (sw_clr),
        .syncwar   (syncwar),
        .sw_set    (sw_set)
    );

    rbuf_flag_core core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .wr_en       (ctl_wr_en),
        .rd_en       (ctl_rd_en),
        .cc_start    (ctl_cc_start),
        .master_on   (ctl_master_on),
        .clr_any     (clr_any),
        .stat0_rd    (stat0_rd),
        .cc_match    (cc_match),
        .dconn_done  (dconn_done),
        .buf_ovf     (buf_ovf),
        .syncwar     (syncwar),
        .sw_set      (sw_set),
        .empty       (empty),
        .wr_meets_rd (wr_meets_rd),
        .rd_go       (rd_go),
        .wrsq        (wrsq),
        .rdsq        (rdsq),
        .ovfl        (ovfl),
        .rdstop      (rdstop)
    );

    // Gather the flags and pack the host status bytes.
    always_comb begin
        flags.empty   = empty;
        flags.ovfl    = ovfl;
        flags.wrsq    = wrsq;
        flags.rdsq    = rdsq;
        flags.syncwar = syncwar;
        flags.rdstop  = rdstop;
        stat0 = pack_stat0(flags);
        stat1 = pack_stat1(flags);
    end

    // R5
    ovfl_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovfl) |-> $past(wr_word && wrsq));

    // R2
    stat_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0[7:2] == '0) && (stat1[3:0] == '0));

endmodule

// File: tb/rbuf_seq_flags_tb.sv
`timescale 1ns/1ps
module rbuf_seq_flags_tb_top;

    localparam int AW = 20;
    localparam int BW = 16;
    localparam int SW = 2352;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_wr_en = 0, ctl_rd_en = 0, ctl_master_on = 0;
    logic [1:0] ctl_cc_start = '0;
    logic clr_rd_addr = 0, clr_wr_addr = 0, stat0_rd = 0;
    logic cc_match = 0, dconn_done = 0, buf_ovf = 0;
    logic sync_ok = 0, sync_fail = 0, byte_tick = 0, wr_word = 0, rd_word = 0;
    logic [7:0] stat0, stat1;
    logic [AW-1:0] wr_addr, rd_addr, vend_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rbuf_seq_flags #(.AW(AW), .BUF_WORDS(BW), .SYNC_WIN(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wr_en(ctl_wr_en),
        .ctl_rd_en(ctl_rd_en), .ctl_cc_start(ctl_cc_start),
        .ctl_master_on(ctl_master_on), .clr_rd_addr(clr_rd_addr),
        .clr_wr_addr(clr_wr_addr), .stat0_rd(stat0_rd), .cc_match(cc_match),
        .dconn_done(dconn_done), .buf_ovf(buf_ovf), .sync_ok(sync_ok),
        .sync_fail(sync_fail), .byte_tick(byte_tick), .wr_word(wr_word),
        .rd_word(rd_word), .stat0(stat0), .stat1(stat1), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .vend_addr(vend_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic cmd(input logic we, input logic re, input logic [1:0] cc, input logic mon);
        ctl_wr = 1; ctl_wr_en = we; ctl_rd_en = re; ctl_cc_start = cc; ctl_master_on = mon;
        tick();
        ctl_wr = 0; ctl_wr_en = 0; ctl_rd_en = 0; ctl_cc_start = '0; ctl_master_on = 0;
    endtask

    task automatic write_words(input int n);
        wr_word = 1;
        repeat (n) tick();
        wr_word = 0;
    endtask

    task automatic read_words(input int n);
        rd_word = 1;
        repeat (n) tick();
        rd_word = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 stat0 after reset", 32'(stat0), 32'h00);
        chk("R1 stat1 after reset", 32'(stat1), 32'h80);
        chk("R1 pointers after reset", 32'(wr_addr | rd_addr | vend_addr), 0);
    endtask

    task automatic t_fill_drain();
        do_reset();
        cmd(1, 0, 2'b00, 1);
        chk("R9 wrsq by command", 32'(stat1), 32'hA0);
        write_words(3);
        chk("R3 write pointer", 32'(wr_addr), 3);
        chk("R4 still empty before commit", 32'(stat1[7]), 1);
        sync_ok = 1; tick(); sync_ok = 0;
        chk("R3 valid-end copy", 32'(vend_addr), 3);
        chk("R4 not empty after commit", 32'(stat1[7]), 0);
        cmd(1, 1, 2'b00, 1);
        chk("R11 rdsq set", 32'(stat1), 32'h30);
        read_words(3);
        chk("R3 read pointer", 32'(rd_addr), 3);
        chk("R4 empty after drain", 32'(stat1), 32'hB0);
        tick();
        chk("R8 read stopped stat0", 32'(stat0), 32'h02);
        chk("R11 rdsq off when empty", 32'(stat1), 32'hA0);
        stat0_rd = 1; tick(); stat0_rd = 0;
        chk("R8 cleared by status read", 32'(stat0), 32'h00);
    endtask

    task automatic t_rd_while_empty();
        do_reset();
        cmd(0, 1, 2'b00, 1);
        chk("R11 read command ignored while empty", 32'(stat1), 32'h80);
        chk("R11 no read-stopped either", 32'(stat0), 32'h00);
    endtask

    task automatic t_overflow();
        do_reset();
        cmd(1, 0, 2'b00, 1);
        write_words(BW);
        chk("R3 write pointer wrapped", 32'(wr_addr), 0);
        chk("R5 overflow set, R10 wrsq dropped", 32'(stat1), 32'hC0);
        clr_rd_addr = 1; tick(); clr_rd_addr = 0;
        chk("R6 overflow cleared by clear, R5 not reset", 32'(stat1), 32'h80);
        tick();
        chk("R5 equal after clear stays clear", 32'(stat1[6]), 0);
        // read advance clears overflow
        do_reset();
        cmd(1, 0, 2'b00, 1);
        write_words(4);
        sync_ok = 1; tick(); sync_ok = 0;
        cmd(1, 1, 2'b00, 1);
        write_words(BW - 4);
        chk("R5 overflow with reader idle", 32'(stat1), 32'h50);
        cmd(1, 1, 2'b00, 1);
        chk("R10 write-enable blocked by overflow", 32'(stat1[5]), 0);
        read_words(1);
        chk("R6 overflow cleared by read advance", 32'(stat1[6]), 0);
        chk("R3 read moved", 32'(rd_addr), 1);
    endtask

    task automatic t_sync();
        do_reset();
        cmd(1, 0, 2'b00, 1);
        sync_fail = 1; tick(); sync_fail = 0;
        chk("R7 sync warning set", 32'(stat0), 32'h01);
        chk("R10 wrsq dropped by sync warning", 32'(stat1[5]), 0);
        cc_match = 1; tick(); cc_match = 0;
        chk("R10 match blocked while warning", 32'(stat1[5]), 0);
        stat0_rd = 1; sync_fail = 1; tick(); stat0_rd = 0; sync_fail = 0;
        chk("R7 clear beats set", 32'(stat0[0]), 0);
        sync_ok = 1; tick(); sync_ok = 0;
        byte_tick = 1;
        repeat (SW - 1) tick();
        byte_tick = 0;
        chk("R7 no timeout one byte early", 32'(stat0[0]), 0);
        byte_tick = 1; tick(); byte_tick = 0;
        chk("R7 timeout at window", 32'(stat0[0]), 1);
        clr_wr_addr = 1; tick(); clr_wr_addr = 0;
        chk("R7 cleared by write-address clear", 32'(stat0[0]), 0);
    endtask

    task automatic t_wrsq_sources();
        do_reset();
        cc_match = 1; tick(); cc_match = 0;
        chk("R9 set by match", 32'(stat1[5]), 1);
        cmd(1, 0, 2'b01, 1);
        chk("R10 write-enable with cc start clears", 32'(stat1[5]), 0);
        dconn_done = 1; tick(); dconn_done = 0;
        chk("R9 set by direct connect", 32'(stat1[5]), 1);
        cmd(1, 0, 2'b00, 0);
        chk("R10 master off clears", 32'(stat1[5]), 0);
        cmd(1, 0, 2'b00, 1);
        buf_ovf = 1; tick(); buf_ovf = 0;
        chk("R10 buffer overflow clears", 32'(stat1[5]), 0);
        cmd(1, 0, 2'b00, 1);
        cc_match = 1;
        cmd(0, 0, 2'b00, 1);
        cc_match = 0;
        chk("R10 write-enable low beats match", 32'(stat1[5]), 0);
    endtask

    task automatic t_clears();
        do_reset();
        cmd(1, 0, 2'b00, 1);
        write_words(5);
        sync_ok = 1; tick(); sync_ok = 0;
        cmd(1, 1, 2'b00, 1);
        read_words(2);
        chk("R3 read two", 32'(rd_addr), 2);
        clr_wr_addr = 1; wr_word = 1; tick(); clr_wr_addr = 0; wr_word = 0;
        chk("R12 write pointer cleared", 32'(wr_addr), 0);
        chk("R12 valid-end cleared", 32'(vend_addr), 0);
        chk("R4 not empty after write clear", 32'(stat1[7]), 0);
        clr_rd_addr = 1; tick(); clr_rd_addr = 0;
        chk("R12 read pointer cleared", 32'(rd_addr), 0);
        chk("R4 empty after both clears", 32'(stat1[7]), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_fill_drain();
        t_rd_while_empty();
        t_overflow();
        t_sync();
        t_wrsq_sources();
        t_clears();
        finish_run();
    end

endmodule